// File: doc/BRIEF.md
# Zero-Wait Bus Memory Slave

This block is a small byte-wide storage array that sits on a simple non-pipelined peripheral bus as one selected target. The bus carries a select vector (one bit per target), an enable strobe, a write flag, an address, and separate write and read data buses. Every transfer takes two clock cycles. In the setup cycle, this target's select bit is high and enable is low. In the access cycle, both are high.

The slave keeps only its own bit of the select vector, chosen by a parameter. It captures the request type and the address in the setup cycle. For a read, it registers the addressed byte onto the read bus at the end of the setup cycle, so the byte is already valid for the whole access cycle and no wait state is needed. For a write, it stores the write-data byte at the captured address on the edge that ends the access cycle. Select may stay high to chain transfers without an idle cycle in between. The storage contents survive reset.

Top module: `bus_mem_slave`

## Requirements
- R1: A synchronous active-high reset drives the read data output to zero, and it reads zero on the first cycle after reset.
- R2: Only bit SLAVE_IDX of the select vector (default bit 0) selects the block. Transfers made with any other select bit neither store data nor change the read data output.
- R3: A setup cycle (own select 1, enable 0, write flag 0) followed by an access cycle presents the stored byte at the setup-cycle address on the read data output, valid throughout the access cycle.
- R4: A setup cycle with write flag 1 followed by an access cycle stores the write data present during the access cycle at the setup-cycle address.
- R5: Write transfers leave the read data output unchanged.
- R6: Back-to-back transfers, where select stays high and each access cycle is followed directly by a new setup cycle, are each performed correctly.
- R7: An access cycle (own select 1, enable 1) that does not directly follow a setup cycle to this block is ignored: nothing is stored.
- R8: Reset does not clear the stored contents, so bytes written before a reset read back unchanged after it.
- R9: The read data output changes only on the edge that ends a read setup cycle, and it holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all transfers sample on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | SEL_W | Target select vector; only bit SLAVE_IDX is used |
| bus_en_i | input | 1 | Access-cycle strobe |
| bus_wr_i | input | 1 | 1 = write transfer, 0 = read transfer |
| bus_addr_i | input | ADDR_W | Byte address, sampled in the setup cycle |
| bus_wdata_i | input | DATA_W | Write data, sampled in the access cycle |
| bus_rdata_o | output | DATA_W | Registered read data |

## Verification
The test stimulus runs in five groups:

1. **Isolated transfers.** Single writes and reads, separated by idle cycles, go to the end addresses and to scattered addresses. This shows that address capture and storage work.
2. **Chained transfers.** Transfers with select held high mix writes and reads. This separates correct re-arming after each access cycle from logic that needs an idle cycle between transfers.
3. **Foreign-select and orphan traffic.** Transfers use a different select bit, and some access cycles have no setup cycle in front of them. Later reads of the same addresses show whether either kind of traffic was wrongly accepted.
4. **Reset mid-run.** A reset is applied after data has been written. Reading the data back afterwards distinguishes a cleared read register from cleared storage.
5. **Mixed sequence.** A longer sequence of writes and reads covers many addresses.

A behavioural model predicts the read bus on every clock, so any early, late or stray change to the read bus is caught.

// File: rtl/bus_mem_slave_pkg.sv
package bus_mem_slave_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } bus_phase_e;

endpackage

// File: rtl/bus_mem_slave_phase.sv
module bus_mem_slave_phase
    import bus_mem_slave_pkg::*;
#(
    parameter int SEL_W     = 8,
    parameter int SLAVE_IDX = 0
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic             en_i,
    output bus_phase_e       phase_o
);

    logic own_sel;

    assign own_sel = sel_i[SLAVE_IDX];

    always_comb begin
        if (!own_sel) begin
            phase_o = PH_IDLE;
        end else if (!en_i) begin
            phase_o = PH_SETUP;
        end else begin
            phase_o = PH_ACCESS;
        end
    end

endmodule

// File: rtl/bus_mem_slave_array.sv
module bus_mem_slave_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] word_q [DEPTH];

    // One register per word with its own decoded enable; no reset on storage.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        logic hit;
        assign hit = we_i && (waddr_i == ADDR_W'(gi));
        always_ff @(posedge clk_i) begin
            if (hit) begin
                word_q[gi] <= wdata_i;
            end
        end
    end

    assign rdata_o = word_q[raddr_i];

endmodule

// File: rtl/bus_mem_slave.sv
module bus_mem_slave
    import bus_mem_slave_pkg::*;
#(
    parameter int SEL_W     = 8,
    parameter int SLAVE_IDX = 0,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [SEL_W-1:0]  bus_sel_i,
    input  logic              bus_en_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o
);

    typedef struct packed {
        logic              pend;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] rdata;
    } slv_state_t;

    slv_state_t        st_d, st_q;
    bus_phase_e        phase;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;

    bus_mem_slave_phase #(
        .SEL_W     (SEL_W),
        .SLAVE_IDX (SLAVE_IDX)
    ) u_phase (
        .sel_i   (bus_sel_i),
        .en_i    (bus_en_i),
        .phase_o (phase)
    );

    bus_mem_slave_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk_i   (clk_i),
        .we_i    (mem_we),
        .waddr_i (st_q.addr),
        .wdata_i (bus_wdata_i),
        .raddr_i (bus_addr_i),
        .rdata_o (mem_rdata)
    );

    // A write commits only in an access cycle armed by a preceding write setup.
    assign mem_we = !rst_i && (phase == PH_ACCESS) && st_q.pend && st_q.is_wr;

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        unique case (phase)
            PH_SETUP: begin
                st_d.pend  = 1'b1;
                st_d.is_wr = bus_wr_i;
                st_d.addr  = bus_addr_i;
                if (!bus_wr_i) begin
                    st_d.rdata = mem_rdata;
                end
            end
            PH_ACCESS: begin
                st_d.pend = 1'b0;
            end
            default: begin
                st_d.pend = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.pend  <= 1'b0;
            st_q.is_wr <= 1'b0;
            st_q.addr  <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o = st_q.rdata;

    // R1
    rst_zero_chk: assert property (@(posedge clk_i)
        rst_i |=> (bus_rdata_o == '0));

    // R2
    foreign_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !bus_sel_i[SLAVE_IDX] |=> $stable(bus_rdata_o));

    // R5
    write_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_sel_i[SLAVE_IDX] && bus_wr_i) |=> $stable(bus_rdata_o));

    // R9
    rd_change_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(bus_rdata_o) && !$past(rst_i)) |->
            $past(bus_sel_i[SLAVE_IDX] && !bus_en_i && !bus_wr_i));

endmodule

// File: tb/bus_mem_slave_tb.sv
module bus_mem_slave_tb;

    localparam int SEL_W  = 8;
    localparam int IDX    = 0;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic [SEL_W-1:0]  sel;
    logic              en;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // Reference model state
    int    ref_mem [int];
    int    exp_rd;
    bit    exp_known;
    bit    m_pend;
    bit    m_wr;
    int    m_addr;

    always #5 clk = ~clk;

    bus_mem_slave #(
        .SEL_W(SEL_W), .SLAVE_IDX(IDX), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_dut (
        .clk_i(clk), .rst_i(rst), .bus_sel_i(sel), .bus_en_i(en),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model updates on each edge from the driven inputs, then compares later.
    always @(posedge clk) begin
        if (rst) begin
            exp_rd = 0; exp_known = 1'b1; m_pend = 1'b0;
        end else if (sel[IDX] && !en) begin
            m_pend = 1'b1; m_wr = wr; m_addr = int'(addr);
            if (!wr) begin
                if (ref_mem.exists(int'(addr))) begin
                    exp_rd = ref_mem[int'(addr)]; exp_known = 1'b1;
                end else begin
                    exp_known = 1'b0;
                end
            end
        end else if (sel[IDX] && en) begin
            if (m_pend && m_wr) ref_mem[m_addr] = int'(wdata);
            m_pend = 1'b0;
        end else begin
            m_pend = 1'b0;
        end
        #2;
        if (exp_known && !done)
            check(int'(rdata) == exp_rd, cur_req, int'(rdata), exp_rd);
    end

    task automatic drive(input logic [SEL_W-1:0] s, input bit e, input bit w,
                         input int a, input int d);
        @(negedge clk);
        sel = s; en = e; wr = w; addr = ADDR_W'(a); wdata = DATA_W'(d);
    endtask

    task automatic idle();
        drive('0, 1'b0, 1'b0, 0, 0);
    endtask

    task automatic xfer(input logic [SEL_W-1:0] s, input bit w, input int a, input int d);
        drive(s, 1'b0, w, a, 8'hEE);
        drive(s, 1'b1, w, a, d);
    endtask

    localparam logic [SEL_W-1:0] OWN   = SEL_W'(1) << IDX;
    localparam logic [SEL_W-1:0] OTHER = SEL_W'(1) << 3;

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sel = '0; en = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        rst = 1'b0;
        idle(); idle();

        // R4: isolated writes at end and scattered addresses
        cur_req = "R4";
        xfer(OWN, 1'b1, 0,    8'h11); idle();
        xfer(OWN, 1'b1, 255,  8'hF0); idle();
        xfer(OWN, 1'b1, 8'h5A, 8'hA5); idle();
        xfer(OWN, 1'b1, 8'h80, 8'h3C); idle();

        // R3: isolated reads of those locations
        cur_req = "R3";
        xfer(OWN, 1'b0, 0,    0); idle();
        xfer(OWN, 1'b0, 255,  0); idle();
        xfer(OWN, 1'b0, 8'h5A, 0); idle();
        xfer(OWN, 1'b0, 8'h80, 0); idle();

        // R5: write after a read must leave the read bus at its last value
        cur_req = "R5";
        xfer(OWN, 1'b0, 8'h5A, 0);
        xfer(OWN, 1'b1, 8'h21, 8'h77); idle();
        check(rdata == 8'hA5, "R5", int'(rdata), 8'hA5);

        // R2: transfers on another select bit are ignored
        cur_req = "R2";
        xfer(OTHER, 1'b1, 0, 8'h99); idle();
        xfer(OTHER, 1'b0, 255, 0); idle();
        check(rdata == 8'hA5, "R2", int'(rdata), 8'hA5);
        xfer(OWN, 1'b0, 0, 0); idle();
        check(rdata == 8'h11, "R2", int'(rdata), 8'h11);

        // R7: access cycle with no setup in front is ignored
        cur_req = "R7";
        drive(OWN, 1'b1, 1'b1, 8'h80, 8'hDE); idle();
        drive(OWN, 1'b1, 1'b1, 8'h80, 8'hDE);
        drive(OWN, 1'b1, 1'b1, 8'h80, 8'hAD); idle();
        xfer(OWN, 1'b0, 8'h80, 0); idle();
        check(rdata == 8'h3C, "R7", int'(rdata), 8'h3C);

        // R6: chained transfers with select held high
        cur_req = "R6";
        xfer(OWN, 1'b1, 8'h10, 8'h01);
        xfer(OWN, 1'b1, 8'h11, 8'h02);
        xfer(OWN, 1'b0, 8'h10, 0);
        xfer(OWN, 1'b1, 8'h10, 8'h03);
        xfer(OWN, 1'b0, 8'h10, 0);
        xfer(OWN, 1'b0, 8'h11, 0);
        idle();
        check(rdata == 8'h02, "R6", int'(rdata), 8'h02);

        // R8: reset keeps storage
        cur_req = "R8";
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(rdata == 8'h00, "R1", int'(rdata), 0);
        xfer(OWN, 1'b0, 255, 0); idle();
        check(rdata == 8'hF0, "R8", int'(rdata), 8'hF0);

        // R9: mixed sequence, model checks the read bus every clock
        cur_req = "R9";
        for (int i = 0; i < 40; i++) xfer(OWN, 1'b1, (i * 37) & 8'hFF, (i * 13 + 5) & 8'hFF);
        for (int i = 0; i < 40; i++) begin
            xfer(OWN, 1'b0, (i * 37) & 8'hFF, 0);
            if (i % 3 == 0) idle();
        end
        idle(); idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule